// File: doc/BRIEF.md
# Serial Device-Select Steering Unit

This block sits between a single three-wire serial write port (an active-low frame strobe, a data line and a bit clock) and a group of serial slaves that share those wires. Each incoming frame opens with a three-bit target code. The block samples that code as it arrives, then lowers the load line of the addressed slave alone, so that every following bit of the frame reaches that slave as it is sent. Data and clock go to every slave all the time. Only the load line picks the slave.

Eight targets are served. Code 0 is a capture register inside the block, codes 1 and 2 are two front-end converters, code 3 is a timing generator, and codes 4 to 7 are spare slaves. The block does not check frame contents and does not read back. For code 0 it shifts the routed bits into a local word and shows that word when the frame closes.

The serial wires are asynchronous to the system clock `clk`. They pass through a synchronizer and edge detector, so every serial transition is seen a few system cycles late, and all outputs leave from registers.

Top module: `sds_steer`

## Requirements
- R1: In the cycle after `rst` is sampled high, all eight `tgt_load_n` lines are high, `loc_update` is low, and `loc_word`, `tgt_clk` and `tgt_data` are zero.
- R2: `tgt_data` and `tgt_clk` copy `ser_data` and `ser_clk` with a latency of SYNC_STAGES+1 system cycles, in every phase of a frame and between frames.
- R3: While `ser_load_n` is low, the first three rising `ser_clk` edges carry the target code, most significant bit first. No load line goes low during those three bits.
- R4: The load line of the decoded target goes low on the first falling `ser_clk` edge after the third code bit, and not at the third rising edge. `tgt_load_n[i]` belongs to code i: 0 is the local capture register, 1 is converter one, 2 is converter two, 3 is the timing generator, and 4 to 7 are the spares.
- R5: At most one load line is low at any time. Once low, it stays low until the frame strobe returns high.
- R6: When `ser_load_n` goes high, all load lines go high at the same latency as R2 and the code counter clears. This applies even if only part of the code was received, and the next frame is decoded from its own first bit.
- R7: Rising `ser_clk` edges while `ser_load_n` is high shift nothing and lower no load line.
- R8: No frame content is checked. A high read/write bit (the first bit after the code) still leaves the selected load line low for the rest of the frame.
- R9: In a code-0 frame, the bits after the code are shifted in so that the first routed bit ends in `loc_word[0]`. When the strobe rises, `loc_word` takes the last LOC_W bits and `loc_update` pulses for one cycle. Frames with any other code leave `loc_word` unchanged and do not pulse `loc_update`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_load_n | input | 1 | Incoming frame strobe, active low |
| ser_data | input | 1 | Incoming serial data |
| ser_clk | input | 1 | Incoming serial bit clock |
| tgt_load_n | output | 8 | Per-target load lines, active low, index = target code |
| tgt_data | output | 1 | Serial data fanned out to all targets |
| tgt_clk | output | 1 | Serial clock fanned out to all targets |
| loc_word | output | 16 | Word captured by the last code-0 frame; bit 0 is the read/write bit, bits 4..1 the address, bits 15..5 the data |
| loc_update | output | 1 | One-cycle pulse when `loc_word` is refreshed |

## Verification
The assertions assume that the serial inputs move slowly compared with `clk`. Each half period of `ser_clk` and each strobe level must last longer than the synchronizer depth plus one cycle. This ensures every edge is seen once, and a falling edge is never merged with the rising edge before it. They also assume that the strobe changes only while `ser_clk` is low. The stimulus holds every serial level for four system cycles and changes data and strobe only in the low phase of the serial clock. It always closes a frame by raising the strobe.

// File: rtl/sds_pkg.sv
package sds_pkg;
  // Phase of the incoming frame
  typedef enum logic {
    PH_SELECT = 1'b0,
    PH_ROUTE  = 1'b1
  } phase_e;

  localparam int SEL_BITS = 3;

  // Target codes whose meaning the rest of the chip relies on
  localparam logic [SEL_BITS-1:0] CODE_LOCAL = 3'd0;
  localparam logic [SEL_BITS-1:0] CODE_FE1   = 3'd1;
  localparam logic [SEL_BITS-1:0] CODE_FE2   = 3'd2;
  localparam logic [SEL_BITS-1:0] CODE_TGEN  = 3'd3;
endpackage

// File: rtl/sds_sync_edge.sv
// Synchronizer for one asynchronous wire, with edge pulses on the synchronized copy
module sds_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {(STAGES+1){RST_VAL}};
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign dout = pipe[STAGES-1];
  assign rise =  pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/sds_select_fsm.sv
// Collects the target code and drives the per-target load lines
module sds_select_fsm
  import sds_pkg::*;
#(
  parameter int SEL_W   = SEL_BITS,
  parameter int NUM_TGT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe_n,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               sdata,
  output phase_e             phase,
  output logic [SEL_W-1:0]   code,
  output logic [NUM_TGT-1:0] load_n
);
  localparam int CNT_W = $clog2(SEL_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SEL_W);

  logic [CNT_W-1:0] cnt;
  logic             grant;

  // Code complete and the serial clock just fell: hand over to the target
  assign grant = (phase == PH_SELECT) && sclk_fall && (cnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst || strobe_n) begin
      cnt   <= '0;
      code  <= '0;
      phase <= PH_SELECT;
    end else if (phase == PH_SELECT) begin
      if (sclk_rise && (cnt != CNT_FULL)) begin
        code <= {code[SEL_W-2:0], sdata};
        cnt  <= cnt + 1'b1;
      end else if (grant) begin
        phase <= PH_ROUTE;
      end
    end
  end

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_load
    always_ff @(posedge clk) begin
      if (rst || strobe_n)                      load_n[i] <= 1'b1;
      else if (grant && (code == SEL_W'(i)))    load_n[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sds_local_capture.sv
// Shift register for frames addressed to the local target
module sds_local_capture #(
  parameter int LOC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_n,
  input  logic             strobe_rise,
  input  logic             sclk_rise,
  input  logic             sdata,
  input  logic             active,
  output logic [LOC_W-1:0] word,
  output logic             update
);
  logic [LOC_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      word   <= '0;
      update <= 1'b0;
    end else begin
      update <= 1'b0;
      if (strobe_rise && active) begin
        word   <= shreg;
        update <= 1'b1;
        shreg  <= '0;
      end else if (strobe_n) begin
        shreg  <= '0;
      end else if (active && sclk_rise) begin
        // first routed bit travels down to bit 0
        shreg  <= {sdata, shreg[LOC_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/sds_steer.sv
module sds_steer
  import sds_pkg::*;
#(
  parameter int SEL_W       = SEL_BITS,
  parameter int SYNC_STAGES = 2,
  parameter int LOC_W       = 16,
  parameter int NUM_TGT     = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_load_n,
  input  logic               ser_data,
  input  logic               ser_clk,
  output logic [NUM_TGT-1:0] tgt_load_n,
  output logic               tgt_data,
  output logic               tgt_clk,
  output logic [LOC_W-1:0]   loc_word,
  output logic               loc_update
);
  localparam int NWIRE = 3;
  localparam int W_LOAD = 0;
  localparam int W_DATA = 1;
  localparam int W_CLK  = 2;
  localparam logic [NWIRE-1:0] WIRE_RST = 3'b001;

  logic [NWIRE-1:0] wire_in, wire_sync, wire_rise, wire_fall;
  logic             load_sync, load_rise, data_sync, clk_sync, clk_rise, clk_fall;
  phase_e           phase;
  logic [SEL_W-1:0] code;
  logic             local_active;

  assign wire_in = {ser_clk, ser_data, ser_load_n};

  for (genvar w = 0; w < NWIRE; w++) begin : g_sync
    sds_sync_edge #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(WIRE_RST[w])
    ) u_sync (
      .clk (clk),
      .rst (rst),
      .din (wire_in[w]),
      .dout(wire_sync[w]),
      .rise(wire_rise[w]),
      .fall(wire_fall[w])
    );
  end

  assign load_sync = wire_sync[W_LOAD];
  assign load_rise = wire_rise[W_LOAD];
  assign data_sync = wire_sync[W_DATA];
  assign clk_sync  = wire_sync[W_CLK];
  assign clk_rise  = wire_rise[W_CLK];
  assign clk_fall  = wire_fall[W_CLK];

  sds_select_fsm #(
    .SEL_W  (SEL_W),
    .NUM_TGT(NUM_TGT)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (load_sync),
    .sclk_rise(clk_rise),
    .sclk_fall(clk_fall),
    .sdata    (data_sync),
    .phase    (phase),
    .code     (code),
    .load_n   (tgt_load_n)
  );

  assign local_active = (phase == PH_ROUTE) && (code == SEL_W'(CODE_LOCAL));

  sds_local_capture #(
    .LOC_W(LOC_W)
  ) u_loc (
    .clk        (clk),
    .rst        (rst),
    .strobe_n   (load_sync),
    .strobe_rise(load_rise),
    .sclk_rise  (clk_rise),
    .sdata      (data_sync),
    .active     (local_active),
    .word       (loc_word),
    .update     (loc_update)
  );

  // Fan-out copies, registered to line up with the load lines
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_data <= 1'b0;
      tgt_clk  <= 1'b0;
    end else begin
      tgt_data <= data_sync;
      tgt_clk  <= clk_sync;
    end
  end
endmodule

// File: rtl/sds_steer_chk.sv
module sds_steer_chk #(
  parameter int NUM_TGT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               strobe_n,
  input logic               sclk_fall,
  input logic [NUM_TGT-1:0] tgt_load_n,
  input logic               loc_update
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (&tgt_load_n && !loc_update));

  // R5
  a_r5_one_target: assert property (@(posedge clk) disable iff (rst)
    $countones(~tgt_load_n) <= 1);

  // R5
  a_r5_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(strobe_n) && !(&$past(tgt_load_n))) |-> $stable(tgt_load_n));

  // R4
  a_r4_drop_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!(&tgt_load_n) && $past(&tgt_load_n)) |-> $past(sclk_fall));

  // R6
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    strobe_n |=> &tgt_load_n);

  // R9
  a_r9_update_at_close: assert property (@(posedge clk) disable iff (rst)
    loc_update |-> $past(strobe_n));
endmodule

bind sds_steer sds_steer_chk #(.NUM_TGT(NUM_TGT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strobe_n  (load_sync),
  .sclk_fall (clk_fall),
  .tgt_load_n(tgt_load_n),
  .loc_update(loc_update)
);

// File: tb/sim_sds_steer.sv
`timescale 1ns/1ps
module sim_sds_steer;
  localparam int H = 4;        // system cycles per serial half period
  localparam int SETTLE = 6;   // beyond the 3-cycle latency

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_load_n = 1'b1;
  logic        ser_data = 1'b0;
  logic        ser_clk = 1'b0;
  logic [7:0]  tgt_load_n;
  logic        tgt_data, tgt_clk;
  logic [15:0] loc_word;
  logic        loc_update;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sds_steer u0 (
    .clk(clk), .rst(rst), .ser_load_n(ser_load_n), .ser_data(ser_data),
    .ser_clk(ser_clk), .tgt_load_n(tgt_load_n), .tgt_data(tgt_data),
    .tgt_clk(tgt_clk), .loc_word(loc_word), .loc_update(loc_update)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    ser_data = b;
    cyc(H);
    ser_clk = 1'b1;
    cyc(H);
    ser_clk = 1'b0;
  endtask

  task automatic open_frame();
    ser_load_n = 1'b0;
    cyc(H);
  endtask

  task automatic send_code(input logic [2:0] c);
    for (int i = 2; i >= 0; i--) sbit(c[i]);
  endtask

  // raise strobe; return loc_update seen in the cycle it can pulse
  task automatic close_frame(output logic upd);
    cyc(H);
    ser_load_n = 1'b1;
    cyc(3);
    upd = loc_update;
    cyc(SETTLE);
  endtask

  function automatic logic [7:0] sel_mask(input int c);
    return ~(8'b1 << c);
  endfunction

  task automatic t_reset();
    chk("R1 load lines", tgt_load_n, 8'hFF);
    chk("R1 loc_word", loc_word, 0);
    chk("R1 loc_update", loc_update, 0);
    chk("R1 tgt_clk", tgt_clk, 0);
    chk("R1 tgt_data", tgt_data, 0);
  endtask

  task automatic t_forward();
    ser_data = 1'b1; cyc(SETTLE);
    chk("R2 data high", tgt_data, 1);
    ser_clk = 1'b1; cyc(SETTLE);
    chk("R2 clk high", tgt_clk, 1);
    ser_clk = 1'b0; ser_data = 1'b0; cyc(SETTLE);
    chk("R2 clk low", tgt_clk, 0);
    chk("R2 data low", tgt_data, 0);
  endtask

  task automatic t_select_timing();
    logic u;
    open_frame();
    sbit(1'b0); sbit(1'b1);
    chk("R3 no load during code", tgt_load_n, 8'hFF);
    ser_data = 1'b1; cyc(H);
    ser_clk = 1'b1; cyc(H);
    chk("R4 not at third rise", tgt_load_n, 8'hFF);
    ser_clk = 1'b0; cyc(SETTLE);
    chk("R4 timing generator selected", tgt_load_n, sel_mask(3));
    ser_data = 1'b1; cyc(SETTLE);
    chk("R2 data during route", tgt_data, 1);
    close_frame(u);
    chk("R6 release after frame", tgt_load_n, 8'hFF);
  endtask

  task automatic t_all_codes();
    logic u;
    for (int c = 0; c < 8; c++) begin
      open_frame();
      send_code(3'(c));
      sbit(1'b0); sbit(1'b1); sbit(1'b0);
      chk($sformatf("R4 code %0d", c), tgt_load_n, sel_mask(c));
      chk("R5 single line low", $countones(~tgt_load_n), 1);
      close_frame(u);
      chk("R6 idle after code", tgt_load_n, 8'hFF);
    end
  endtask

  task automatic t_abort();
    logic u;
    open_frame();
    sbit(1'b1); sbit(1'b1);
    close_frame(u);
    chk("R6 abort keeps idle", tgt_load_n, 8'hFF);
    open_frame();
    send_code(3'b010);
    sbit(1'b0);
    chk("R6 fresh decode after abort", tgt_load_n, sel_mask(2));
    close_frame(u);
  endtask

  task automatic t_idle_edges();
    logic u;
    for (int i = 0; i < 5; i++) sbit(1'b1);
    chk("R7 idle edges lower nothing", tgt_load_n, 8'hFF);
    open_frame();
    send_code(3'b001);
    sbit(1'b0);
    chk("R7 decode unaffected by idle edges", tgt_load_n, sel_mask(1));
    close_frame(u);
  endtask

  task automatic t_rw_high();
    logic u;
    open_frame();
    send_code(3'b011);
    sbit(1'b1);
    chk("R8 high rw still routed", tgt_load_n, sel_mask(3));
    for (int i = 0; i < 6; i++) sbit(1'b1);
    chk("R8 held through frame", tgt_load_n, sel_mask(3));
    close_frame(u);
  endtask

  task automatic t_local(input logic [15:0] w);
    logic u;
    open_frame();
    send_code(3'b000);
    for (int i = 0; i < 16; i++) sbit(w[i]);
    chk("R9 local line low", tgt_load_n, sel_mask(0));
    close_frame(u);
    chk("R9 update pulse", u, 1);
    chk("R9 update one cycle", loc_update, 0);
    chk("R9 captured word", loc_word, w);
  endtask

  task automatic t_local_untouched(input logic [15:0] keep);
    logic u;
    open_frame();
    send_code(3'b010);
    for (int i = 0; i < 16; i++) sbit(1'b1);
    close_frame(u);
    chk("R9 no pulse for other code", u, 0);
    chk("R9 word kept", loc_word, keep);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_forward();
    t_select_timing();
    t_all_codes();
    t_abort();
    t_idle_edges();
    t_rw_high();
    t_local(16'hA5C3);
    t_local(16'h3C96);
    t_local_untouched(16'h3C96);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule